// File: doc/BRIEF.md
# Trace Alignment and Breakpoint Controller

This block is the control state machine between a debug trigger source and a circular trace store. It watches a comparator trigger pulse and a software force-trigger pulse. It decides, from a two-bit alignment code, which store strobes become trace writes before and after the trigger. It also decides when the session is complete and when a breakpoint request is raised. That request is held back until the chosen alignment has finished collecting entries, unless the break-immediately bit asks for it at once.

A completed request is routed. It goes to a debug-monitor entry line or to a software-interrupt line, according to the enable and monitor-select bits. Nothing is raised while the monitor is already running. A software-interrupt instruction from user code passes through to the interrupt line, unless a monitor request fires in the same cycle. In that case the monitor request wins.

Top module: `trace_brk_ctrl`

## Requirements
- R1: With alignment code 00, every store strobe while armed is written, including the strobe in the trigger cycle. The trigger completes the session, and later strobes are not written.
- R2: With alignment code 01, strobes before the trigger and in the trigger cycle are not written. Strobes after the trigger are written until a cycle with the buffer-full input high. That cycle is not written and completes the session.
- R3: With alignment code 10, strobes before the trigger and in the trigger cycle are written. Exactly POST_CNT (32) further strobes are written after the trigger, and the last of them completes the session.
- R4: When the break-immediately bit is set under codes 00, 01 or 10, a trigger completes the session at once. The routed request pulses in the cycle after the trigger.
- R5: With the breakpoint-enable bit at 0, sessions still complete, but neither request line pulses for a trigger.
- R6: While disarmed, the comparator trigger has no effect. The force-trigger moves the block to its final state and raises the routed request in the next cycle.
- R7: A force-trigger while armed under code 01 or 10 starts the post-trigger phase. The request and the complete flag appear only when that phase ends.
- R8: After the first accepted trigger, further comparator triggers and force-triggers have no effect. This holds both during the post-trigger phase and in the final state.
- R9: A request goes to the monitor line when the monitor-select bit is 1. It goes to the software-interrupt line when that bit is 0. No request is raised while monitor-active is high.
- R10: A user software-interrupt input pulses the software-interrupt line one cycle later, unless a monitor request fires in that same cycle. Then only the monitor line pulses.
- R11: The complete flag stays high until the arm input rises again, and that rising edge clears it and re-arms the block.
- R12: With alignment code 11 no strobe is written and no request is raised; a trigger still marks the session complete.
- R13: After reset all outputs are 0, and each request line is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_align | input | 2 | Alignment code: 00 end, 01 begin, 10 middle, 11 reserved |
| cfg_brk_now | input | 1 | Complete the session and request on the trigger |
| cfg_brk_en | input | 1 | Allow breakpoint requests |
| cfg_mon_sel | input | 1 | 1 routes requests to the monitor, 0 to software interrupt |
| arm | input | 1 | Arm level; a rising edge re-arms after completion |
| cmp_trig | input | 1 | Comparator trigger pulse |
| sw_trig | input | 1 | Software force-trigger pulse |
| store_stb | input | 1 | One trace entry is available this cycle |
| buf_full | input | 1 | Trace store is full |
| mon_active | input | 1 | Debug monitor is running |
| user_swi | input | 1 | User code executes a software-interrupt instruction |
| trace_we | output | 1 | Write this cycle's entry into the trace store |
| trace_done | output | 1 | Trace session complete |
| mon_req | output | 1 | Monitor entry request pulse |
| swi_req | output | 1 | Software-interrupt request pulse |

## Verification
The bench builds the block with POST_CNT at its default of 32, so the six-bit post-trigger counter reaches its terminal value. This lets the bench confirm that exactly 32 strobes, arriving every other cycle, are written after a middle-aligned trigger. Late triggers are injected in the middle of that window to show they do not shorten it. The reserved code, the disarmed force-trigger and the collision between a monitor request and a user interrupt are each driven through their own session.

// File: rtl/tabc_pkg.sv
package tabc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_POST  = 2'd2,
        ST_DONE  = 2'd3
    } tabc_state_e;

    typedef enum logic [1:0] {
        AL_END   = 2'b00,
        AL_BEGIN = 2'b01,
        AL_MID   = 2'b10,
        AL_RSV   = 2'b11
    } tabc_align_e;

    typedef struct packed {
        logic en;
        logic sel;
        logic active;
    } tabc_route_t;

    // codes that may raise a breakpoint
    function automatic logic align_req_ok(tabc_align_e a);
        return a != AL_RSV;
    endfunction

    // codes that record entries before the trigger
    function automatic logic align_stores_pre(tabc_align_e a);
        return (a == AL_END) || (a == AL_MID);
    endfunction

    // codes that need a post-trigger phase
    function automatic logic align_has_post(tabc_align_e a);
        return (a == AL_BEGIN) || (a == AL_MID);
    endfunction

endpackage

// File: rtl/tabc_post_counter.sv
module tabc_post_counter #(
    parameter int POST_CNT = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic hit
);
    localparam int CW = $clog2(POST_CNT + 1);
    localparam logic [CW-1:0] LAST = CW'(POST_CNT - 1);
    localparam logic [CW-1:0] TOPV = CW'(POST_CNT);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (inc && (cnt != TOPV))
            cnt <= cnt + 1'b1;
    end

    assign hit = inc && (cnt == LAST);

    // the FSM must leave the post phase on the terminal strobe
    assert_hit_once_R3: assert property (@(posedge clk) disable iff (rst)
        hit |=> !hit);

endmodule

// File: rtl/tabc_align_fsm.sv
module tabc_align_fsm
    import tabc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  tabc_align_e align,
    input  logic        brk_now,
    input  logic        arm,
    input  logic        arm_rise,
    input  logic        cmp_trig,
    input  logic        sw_trig,
    input  logic        store_stb,
    input  logic        buf_full,
    input  logic        post_hit,
    output tabc_state_e state,
    output logic        trace_we,
    output logic        cnt_clr,
    output logic        cnt_inc,
    output logic        fire
);
    tabc_state_e st, st_n;
    tabc_align_e lmode, lmode_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            lmode <= AL_END;
        end else begin
            st    <= st_n;
            lmode <= lmode_n;
        end
    end

    always_comb begin
        st_n    = st;
        lmode_n = lmode;
        fire    = 1'b0;
        cnt_clr = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (sw_trig) begin
                    st_n = ST_DONE;
                    fire = align_req_ok(align);
                end else if (arm) begin
                    st_n = ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (!arm) begin
                    if (sw_trig) begin
                        st_n = ST_DONE;
                        fire = align_req_ok(align);
                    end else begin
                        st_n = ST_IDLE;
                    end
                end else if (cmp_trig || sw_trig) begin
                    if (!align_req_ok(align)) begin
                        st_n = ST_DONE;
                    end else if (brk_now || !align_has_post(align)) begin
                        st_n = ST_DONE;
                        fire = 1'b1;
                    end else begin
                        st_n    = ST_POST;
                        lmode_n = align;
                        cnt_clr = 1'b1;
                    end
                end
            end
            ST_POST: begin
                if (!arm) begin
                    st_n = ST_IDLE;
                end else if ((lmode == AL_BEGIN) && buf_full) begin
                    st_n = ST_DONE;
                    fire = 1'b1;
                end else if ((lmode == AL_MID) && post_hit) begin
                    st_n = ST_DONE;
                    fire = 1'b1;
                end
            end
            ST_DONE: begin
                if (arm_rise)
                    st_n = ST_ARMED;
            end
            default: st_n = ST_IDLE;
        endcase
    end

    assign cnt_inc = (st == ST_POST) && (lmode == AL_MID) && store_stb;

    always_comb begin
        trace_we = 1'b0;
        if (st == ST_ARMED)
            trace_we = store_stb && align_stores_pre(align);
        else if (st == ST_POST)
            trace_we = store_stb && ((lmode == AL_MID) ||
                                     ((lmode == AL_BEGIN) && !buf_full));
    end

    assign state = st;

    // once final, only a re-arm edge may leave
    assert_late_trig_R8: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DONE && !arm_rise) |=> (st == ST_DONE));

    // reserved code never writes while armed
    assert_rsv_nowrite_R12: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ARMED && align == AL_RSV) |-> !trace_we);

    // a post phase always uses an alignment that has one
    assert_post_mode_R7: assert property (@(posedge clk) disable iff (rst)
        (st == ST_POST) |-> align_has_post(lmode));

endmodule

// File: rtl/tabc_brk_router.sv
module tabc_brk_router
    import tabc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        fire,
    input  tabc_route_t route,
    input  logic        user_swi,
    output logic        mon_req,
    output logic        swi_req
);
    logic dbg_go, mon_n, swi_n;

    always_comb begin
        dbg_go = fire && route.en && !route.active;
        mon_n  = dbg_go && route.sel;
        swi_n  = (dbg_go && !route.sel) || (user_swi && !mon_n);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mon_req <= 1'b0;
            swi_req <= 1'b0;
        end else begin
            mon_req <= mon_n;
            swi_req <= swi_n;
        end
    end

    assert_pulse_R13: assert property (@(posedge clk) disable iff (rst)
        mon_req |=> !mon_req);

    assert_route_R9: assert property (@(posedge clk) disable iff (rst)
        mon_req |-> $past(route.sel && !route.active));

    assert_prio_R10: assert property (@(posedge clk) disable iff (rst)
        mon_req |-> !swi_req);

    assert_enable_R5: assert property (@(posedge clk) disable iff (rst)
        (swi_req && !$past(user_swi)) |-> $past(route.en));

endmodule

// File: rtl/trace_brk_ctrl.sv
module trace_brk_ctrl
    import tabc_pkg::*;
#(
    parameter int POST_CNT = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] cfg_align,
    input  logic       cfg_brk_now,
    input  logic       cfg_brk_en,
    input  logic       cfg_mon_sel,
    input  logic       arm,
    input  logic       cmp_trig,
    input  logic       sw_trig,
    input  logic       store_stb,
    input  logic       buf_full,
    input  logic       mon_active,
    input  logic       user_swi,
    output logic       trace_we,
    output logic       trace_done,
    output logic       mon_req,
    output logic       swi_req
);
    logic        arm_q, arm_rise;
    logic        post_hit, cnt_clr, cnt_inc, fire;
    tabc_state_e state;
    tabc_route_t route;

    always_ff @(posedge clk) begin
        if (rst) arm_q <= 1'b0;
        else     arm_q <= arm;
    end
    assign arm_rise = arm && !arm_q;

    assign route = '{en: cfg_brk_en, sel: cfg_mon_sel, active: mon_active};

    tabc_post_counter #(.POST_CNT(POST_CNT)) u_cnt (
        .clk (clk),
        .rst (rst),
        .clr (cnt_clr),
        .inc (cnt_inc),
        .hit (post_hit)
    );

    tabc_align_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .align     (tabc_align_e'(cfg_align)),
        .brk_now   (cfg_brk_now),
        .arm       (arm),
        .arm_rise  (arm_rise),
        .cmp_trig  (cmp_trig),
        .sw_trig   (sw_trig),
        .store_stb (store_stb),
        .buf_full  (buf_full),
        .post_hit  (post_hit),
        .state     (state),
        .trace_we  (trace_we),
        .cnt_clr   (cnt_clr),
        .cnt_inc   (cnt_inc),
        .fire      (fire)
    );

    tabc_brk_router u_rt (
        .clk      (clk),
        .rst      (rst),
        .fire     (fire),
        .route    (route),
        .user_swi (user_swi),
        .mon_req  (mon_req),
        .swi_req  (swi_req)
    );

    assign trace_done = (state == ST_DONE);

    // the complete flag only drops on a re-arm edge
    assert_done_hold_R11: assert property (@(posedge clk) disable iff (rst)
        $fell(trace_done) |-> ($past(arm) && !$past(arm, 2)));

endmodule

// File: tb/sim_trace_brk_ctrl.sv
module sim_trace_brk_ctrl;
    localparam int POSTN = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] cfg_align = 2'b00;
    logic cfg_brk_now = 0, cfg_brk_en = 1, cfg_mon_sel = 1, arm = 0;
    logic cmp_trig = 0, sw_trig = 0, store_stb = 0, buf_full = 0;
    logic mon_active = 0, user_swi = 0;
    logic trace_we, trace_done, mon_req, swi_req;

    trace_brk_ctrl #(.POST_CNT(POSTN)) u0 (
        .clk(clk), .rst(rst), .cfg_align(cfg_align), .cfg_brk_now(cfg_brk_now),
        .cfg_brk_en(cfg_brk_en), .cfg_mon_sel(cfg_mon_sel), .arm(arm),
        .cmp_trig(cmp_trig), .sw_trig(sw_trig), .store_stb(store_stb),
        .buf_full(buf_full), .mon_active(mon_active), .user_swi(user_swi),
        .trace_we(trace_we), .trace_done(trace_done), .mon_req(mon_req),
        .swi_req(swi_req)
    );

    always #4 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    int we_cnt = 0, mon_cnt = 0, swi_cnt = 0;
    bit go = 0;
    string cur_req = "R13";

    // behavioural reference: phase 0 idle, 1 armed, 2 post, 3 final
    int m_ph = 0, m_left = 0, m_mode = 0;
    bit m_armp = 0, m_mon = 0, m_swi = 0;

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        bit ewe, fire, nmon, dbg;
        int a;
        a = int'(cfg_align);
        ewe = store_stb && ((m_ph == 1 && (a == 0 || a == 2)) ||
              (m_ph == 2 && (m_mode == 2 || (m_mode == 1 && !buf_full))));
        if (go) begin
            check(trace_we == ewe, cur_req, "trace_we", int'(trace_we), int'(ewe));
            check(trace_done == (m_ph == 3), cur_req, "trace_done", int'(trace_done), int'(m_ph == 3));
            check(mon_req == m_mon, cur_req, "mon_req", int'(mon_req), int'(m_mon));
            check(swi_req == m_swi, cur_req, "swi_req", int'(swi_req), int'(m_swi));
        end
        we_cnt  += int'(trace_we);
        mon_cnt += int'(mon_req);
        swi_cnt += int'(swi_req);
        fire = 0;
        if (m_ph == 0 || (m_ph == 1 && !arm)) begin
            if (sw_trig) begin m_ph = 3; fire = (a != 3); end
            else m_ph = arm ? 1 : 0;
        end else if (m_ph == 1) begin
            if (cmp_trig || sw_trig) begin
                if (a == 3) m_ph = 3;
                else if (cfg_brk_now || a == 0) begin m_ph = 3; fire = 1; end
                else begin m_ph = 2; m_mode = a; m_left = POSTN; end
            end
        end else if (m_ph == 2) begin
            if (!arm) m_ph = 0;
            else if (m_mode == 1 && buf_full) begin m_ph = 3; fire = 1; end
            else if (m_mode == 2 && store_stb) begin
                m_left--;
                if (m_left == 0) begin m_ph = 3; fire = 1; end
            end
        end else begin
            if (arm && !m_armp) m_ph = 1;
        end
        dbg = fire && cfg_brk_en && !mon_active;
        nmon = dbg && cfg_mon_sel;
        m_swi = (dbg && !cfg_mon_sel) || (user_swi && !nmon);
        m_mon = nmon;
        m_armp = arm;
        if (rst) begin
            m_ph = 0; m_mon = 0; m_swi = 0; m_armp = 0;
        end
    end

    task automatic tick(int n = 1);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic zero();
        we_cnt = 0; mon_cnt = 0; swi_cnt = 0;
    endtask

    task automatic rearm();
        store_stb = 0; arm = 0; tick();
        arm = 1; tick(2);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary();
    end

    initial begin
        tick(2);
        go = 1;
        tick(); rst = 0; #1;
        // R13 reset state
        check(!trace_we && !trace_done && !mon_req && !swi_req, "R13", "reset outputs",
              int'({trace_we, trace_done, mon_req, swi_req}), 0);

        // R1 end-aligned
        cur_req = "R1"; rearm(); zero();
        store_stb = 1; tick(6);
        cmp_trig = 1; tick(); cmp_trig = 0;
        tick(4); store_stb = 0;
        check(we_cnt == 7, "R1", "writes", we_cnt, 7);
        check(trace_done, "R1", "done", int'(trace_done), 1);
        check(mon_cnt == 1 && swi_cnt == 0, "R13", "single mon pulse", mon_cnt, 1);
        cur_req = "R8"; cmp_trig = 1; sw_trig = 1; tick(); cmp_trig = 0; sw_trig = 0; tick(2);
        check(mon_cnt == 1, "R8", "late trigger in final", mon_cnt, 1);

        // R2 begin-aligned, forced trigger, software interrupt route
        cur_req = "R2"; cfg_align = 2'b01; cfg_mon_sel = 0; rearm(); zero();
        store_stb = 1; tick(5);
        check(we_cnt == 0, "R2", "pre-trigger writes", we_cnt, 0);
        sw_trig = 1; tick(); sw_trig = 0;
        tick(7);
        check(!trace_done && swi_cnt == 0, "R7", "request deferred", swi_cnt, 0);
        buf_full = 1; tick(); buf_full = 0; store_stb = 0; tick(2);
        check(we_cnt == 7, "R2", "post writes", we_cnt, 7);
        check(swi_cnt == 1 && mon_cnt == 0, "R9", "swi route", swi_cnt, 1);

        // R3 mid-aligned, 32 further entries, late triggers ignored
        cur_req = "R3"; cfg_align = 2'b10; cfg_mon_sel = 1; rearm(); zero();
        store_stb = 1; tick(4);
        cmp_trig = 1; tick(); cmp_trig = 0;
        check(we_cnt == 5, "R3", "pre and trigger writes", we_cnt, 5);
        zero();
        for (int i = 0; i < 80; i++) begin
            store_stb = (i % 2 == 0);
            cmp_trig = (i == 20); sw_trig = (i == 20);
            if (i == 40)
                check(!trace_done, "R8", "late triggers kept window", int'(trace_done), 0);
            tick();
        end
        cmp_trig = 0; sw_trig = 0; store_stb = 0; tick(2);
        check(we_cnt == POSTN, "R3", "post writes", we_cnt, POSTN);
        check(mon_cnt == 1 && trace_done, "R3", "completion request", mon_cnt, 1);

        // R4 break immediately under begin alignment
        cur_req = "R4"; cfg_align = 2'b01; cfg_brk_now = 1; rearm(); zero();
        store_stb = 1; cmp_trig = 1; tick(); cmp_trig = 0; tick(3); store_stb = 0;
        check(we_cnt == 0 && mon_cnt == 1 && trace_done, "R4", "immediate break", mon_cnt, 1);
        cfg_brk_now = 0; cfg_align = 2'b00;

        // R5 breakpoints disabled
        cur_req = "R5"; cfg_brk_en = 0; rearm(); zero();
        cmp_trig = 1; tick(); cmp_trig = 0; tick(2);
        check(mon_cnt == 0 && swi_cnt == 0 && trace_done, "R5", "no request", mon_cnt + swi_cnt, 0);
        cfg_brk_en = 1;

        // R6 disarmed triggers
        cur_req = "R6"; rearm(); arm = 0; tick(2); zero();
        cmp_trig = 1; tick(); cmp_trig = 0; tick(2);
        check(!trace_done && mon_cnt == 0, "R6", "comparator ignored disarmed", int'(trace_done), 0);
        sw_trig = 1; tick(); sw_trig = 0; tick(2);
        check(trace_done && mon_cnt == 1, "R6", "forced trigger disarmed", mon_cnt, 1);

        // R9 monitor active blocks requests
        cur_req = "R9"; mon_active = 1; rearm(); zero();
        cmp_trig = 1; tick(); cmp_trig = 0; tick(2);
        check(mon_cnt == 0 && swi_cnt == 0, "R9", "monitor active", mon_cnt + swi_cnt, 0);
        mon_active = 0;

        // R10 user interrupt pass-through and collision
        cur_req = "R10"; zero();
        user_swi = 1; tick(); user_swi = 0; tick(2);
        check(swi_cnt == 1 && mon_cnt == 0, "R10", "user swi passes", swi_cnt, 1);
        rearm(); zero();
        cmp_trig = 1; user_swi = 1; tick(); cmp_trig = 0; user_swi = 0; tick(2);
        check(mon_cnt == 1 && swi_cnt == 0, "R10", "monitor wins collision", swi_cnt, 0);

        // R11 complete flag hold
        cur_req = "R11"; tick(5);
        check(trace_done, "R11", "held while arm high", int'(trace_done), 1);
        arm = 0; tick(3);
        check(trace_done, "R11", "held while arm low", int'(trace_done), 1);
        arm = 1; tick();
        check(!trace_done, "R11", "cleared on re-arm", int'(trace_done), 0);

        // R12 reserved code
        cur_req = "R12"; cfg_align = 2'b11; tick(); zero();
        store_stb = 1; tick(5);
        cmp_trig = 1; tick(); cmp_trig = 0; tick(3); store_stb = 0;
        check(we_cnt == 0 && mon_cnt == 0 && swi_cnt == 0, "R12", "reserved silent", we_cnt + mon_cnt, 0);
        check(trace_done, "R12", "reserved completes", int'(trace_done), 1);

        tick(2);
        summary();
    end
endmodule